// File: doc/BRIEF.md
# Partitionable Multistage Cube Switch

This block is a multistage cube switch with N = 2^M ports. It has M stages of N/2 two-by-two exchange boxes. The stages run from address bit M-1 at the inputs down to bit 0 at the outputs. In the stage that handles bit i, each box joins the two links whose indices differ only in bit i. Each input port offers one data word, a valid flag and a destination port number. Every box sets itself from the destination bit of the stage it serves: it stays straight when the packet already sits on the link with the correct bit, and it swaps the two links otherwise.

A partition mask holds one bit per stage. When a mask bit is set, every box in that stage stays straight. Traffic then cannot change that address bit, so the switch splits into independent sub-switches, each made of the ports that share the fixed bits. A packet that would have to cross a forced stage is dropped, and the illegal flag for that stage is raised. When two packets in one box need the same output link, the packet on the link with bit i = 0 wins and the other is dropped. The conflict flag for that stage is then raised.

The flags travel through the pipeline with the data, so they always describe the set of words shown at the outputs. Parameter STAGE_REG selects a register after every stage (latency M cycles) or a single output register (latency 1). In both cases a new set of words can enter every cycle.

Top module: `gcube_net`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, out_valid, conflict and illegal are all zero.
- R2: With STAGE_REG = 1, a word set applied before a rising edge appears at the outputs after exactly M rising edges, and a new word set can be applied at every edge.
- R3: A valid packet that meets no conflict and no forced stage leaves on output port in_dest (port j uses in_data[j*W +: W] and in_dest[j*M +: M]) with its data unchanged. This holds for every permutation of the form dest = src XOR k.
- R4: When both packets in a stage-i box need the same output link, the packet arriving on the link whose bit i is 0 wins. The other packet is dropped and conflict[i] is set for that word set.
- R5: When part_mask[i] = 1, every stage-i box stays straight. A packet whose source and destination differ in bit i is dropped, and illegal[i] is set for that word set.
- R6: Packets whose source and destination agree in every masked bit are delivered normally, with no illegal flag.
- R7: Inputs with in_valid low produce no output and raise no flag, whatever their destination.
- R8: The flags belong to the word set they travel with. A clean word set that follows a faulty one shows all flags at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N | Per-port request valid |
| in_data | input | N*W | Per-port data words, port j at [j*W +: W] |
| in_dest | input | N*M | Per-port destination index, port j at [j*M +: M] |
| part_mask | input | M | Bit i = 1 forces stage i straight |
| out_valid | output | N | Per-port delivered flag |
| out_data | output | N*W | Per-port delivered data |
| conflict | output | M | Bit i: a stage-i box dropped a packet to a conflict |
| illegal | output | M | Bit i: a packet needed to cross forced stage i |

## Verification
A box that sets itself wrongly sends a word to the wrong output port or drops it. The fault shows at out_valid and out_data at the exact latency of the word set that met it. A conflict or illegal flag that is lost or left stuck shows on the same cycle as the data it belongs to. A wrong flag also shows on the next clean word set, one cycle later. A pipeline register that loses alignment moves data or flags by whole cycles, and the back-to-back test catches this.

// File: rtl/gcube_pkg.sv
package gcube_pkg;
   // Index of the link with bit `bit_i` = 0 served by box `box` of a stage.
   function automatic int lo_link(input int box, input int bit_i);
      int low;
      low = box & ((1 << bit_i) - 1);
      return ((box >> bit_i) << (bit_i + 1)) | low;
   endfunction
endpackage

// File: rtl/gcube_box.sv
module gcube_box #(
   parameter int W = 8,
   parameter int M = 3,
   parameter int I = 0
) (
   input  logic         force_st,
   input  logic         lo_v,
   input  logic [W-1:0] lo_d,
   input  logic [M-1:0] lo_t,
   input  logic         hi_v,
   input  logic [W-1:0] hi_d,
   input  logic [M-1:0] hi_t,
   output logic         up_v,
   output logic [W-1:0] up_d,
   output logic [M-1:0] up_t,
   output logic         dn_v,
   output logic [W-1:0] dn_d,
   output logic [M-1:0] dn_t,
   output logic         conf,
   output logic         ill
);
   always_comb begin
      up_v = 1'b0; up_d = lo_d; up_t = lo_t;
      dn_v = 1'b0; dn_d = hi_d; dn_t = hi_t;
      conf = 1'b0;
      ill  = 1'b0;
      if (force_st) begin
         up_v = lo_v & ~lo_t[I];
         dn_v = hi_v &  hi_t[I];
         ill  = (lo_v & lo_t[I]) | (hi_v & ~hi_t[I]);
      end else begin
         conf = lo_v & hi_v & (lo_t[I] == hi_t[I]);
         if (lo_v) begin
            if (lo_t[I]) begin
               dn_v = 1'b1; dn_d = lo_d; dn_t = lo_t;
            end else begin
               up_v = 1'b1; up_d = lo_d; up_t = lo_t;
            end
         end
         if (hi_v && !conf) begin
            if (hi_t[I]) begin
               dn_v = 1'b1; dn_d = hi_d; dn_t = hi_t;
            end else begin
               up_v = 1'b1; up_d = hi_d; up_t = hi_t;
            end
         end
      end
   end
endmodule

// File: rtl/gcube_stage.sv
module gcube_stage #(
   parameter int M   = 3,
   parameter int W   = 8,
   parameter int I   = 0,
   parameter bit REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             force_st,
   input  logic [(1<<M)-1:0]   in_v,
   input  logic [(1<<M)*W-1:0] in_d,
   input  logic [(1<<M)*M-1:0] in_t,
   input  logic [M-1:0]     cin,
   input  logic [M-1:0]     iin,
   output logic [(1<<M)-1:0]   out_v,
   output logic [(1<<M)*W-1:0] out_d,
   output logic [(1<<M)*M-1:0] out_t,
   output logic [M-1:0]     cout,
   output logic [M-1:0]     iout
);
   localparam int N  = 1 << M;
   localparam int NB = N / 2;

   logic [N-1:0]   nxt_v;
   logic [N*W-1:0] nxt_d;
   logic [N*M-1:0] nxt_t;
   logic [NB-1:0]  bconf, bill;
   logic [M-1:0]   c_nxt, i_nxt;

   for (genvar b = 0; b < NB; b++) begin : g_box
      localparam int LO = gcube_pkg::lo_link(b, I);
      localparam int HI = LO + (1 << I);
      gcube_box #(.W(W), .M(M), .I(I)) u_box (
         .force_st (force_st),
         .lo_v (in_v[LO]), .lo_d (in_d[LO*W +: W]), .lo_t (in_t[LO*M +: M]),
         .hi_v (in_v[HI]), .hi_d (in_d[HI*W +: W]), .hi_t (in_t[HI*M +: M]),
         .up_v (nxt_v[LO]), .up_d (nxt_d[LO*W +: W]), .up_t (nxt_t[LO*M +: M]),
         .dn_v (nxt_v[HI]), .dn_d (nxt_d[HI*W +: W]), .dn_t (nxt_t[HI*M +: M]),
         .conf (bconf[b]),
         .ill  (bill[b])
      );
   end

   always_comb begin
      c_nxt    = cin;
      i_nxt    = iin;
      c_nxt[I] = cin[I] | (|bconf);
      i_nxt[I] = iin[I] | (|bill);
   end

   if (REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_v <= '0; out_d <= '0; out_t <= '0; cout <= '0; iout <= '0;
         end else begin
            out_v <= nxt_v; out_d <= nxt_d; out_t <= nxt_t;
            cout  <= c_nxt; iout  <= i_nxt;
         end
      end
   end else begin : g_comb
      assign out_v = nxt_v;
      assign out_d = nxt_d;
      assign out_t = nxt_t;
      assign cout  = c_nxt;
      assign iout  = i_nxt;
   end

   for (genvar j = 0; j < N; j++) begin : g_chk
      localparam bit JB = 1'(((j >> I) & 1));
      AST_TAG_BIT: assert property (@(posedge clk) disable iff (!rst_n)
         nxt_v[j] |-> (nxt_t[j*M+I] == JB)); // R3
      AST_SRC_VALID: assert property (@(posedge clk) disable iff (!rst_n)
         nxt_v[j] |-> (in_v[j] || in_v[j ^ (1 << I)])); // R7
      AST_FORCED_STRAIGHT: assert property (@(posedge clk) disable iff (!rst_n)
         (force_st && nxt_v[j]) |-> (in_v[j] && nxt_d[j*W +: W] == in_d[j*W +: W])); // R5
   end
   AST_CONF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (|bconf) |-> ($countones(nxt_v) < $countones(in_v))); // R4
   AST_FORCED_NO_CONF: assert property (@(posedge clk) disable iff (!rst_n)
      force_st |-> !(|bconf)); // R5
endmodule

// File: rtl/gcube_net.sv
module gcube_net #(
   parameter int M         = 3,
   parameter int W         = 8,
   parameter bit STAGE_REG = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [(1<<M)-1:0]    in_valid,
   input  logic [(1<<M)*W-1:0]  in_data,
   input  logic [(1<<M)*M-1:0]  in_dest,
   input  logic [M-1:0]         part_mask,
   output logic [(1<<M)-1:0]    out_valid,
   output logic [(1<<M)*W-1:0]  out_data,
   output logic [M-1:0]         conflict,
   output logic [M-1:0]         illegal
);
   localparam int N = 1 << M;

   if (M < 1 || M > 8) begin : g_bad_m
      $error("gcube_net: M must lie in 1..8");
   end
   if (W < 1) begin : g_bad_w
      $error("gcube_net: W must be at least 1");
   end

   logic [M:0][N-1:0]   sv;
   logic [M:0][N*W-1:0] sd;
   logic [M:0][N*M-1:0] st;
   logic [M:0][M-1:0]   sc, si;

   assign sv[0] = in_valid;
   assign sd[0] = in_data;
   assign st[0] = in_dest;
   assign sc[0] = '0;
   assign si[0] = '0;

   for (genvar k = 0; k < M; k++) begin : g_stage
      localparam int I   = M - 1 - k;
      localparam bit REG = STAGE_REG || (k == M - 1);
      gcube_stage #(.M(M), .W(W), .I(I), .REG(REG)) u_stage (
         .clk (clk), .rst_n (rst_n), .force_st (part_mask[I]),
         .in_v (sv[k]), .in_d (sd[k]), .in_t (st[k]), .cin (sc[k]), .iin (si[k]),
         .out_v (sv[k+1]), .out_d (sd[k+1]), .out_t (st[k+1]),
         .cout (sc[k+1]), .iout (si[k+1])
      );
   end

   assign out_valid = sv[M];
   assign out_data  = sd[M];
   assign conflict  = sc[M];
   assign illegal   = si[M];

   for (genvar j = 0; j < N; j++) begin : g_out_chk
      AST_DELIVER_PORT: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[j] |-> (st[M][j*M +: M] == M'(j))); // R3
   end
   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (out_valid == '0 && conflict == '0 && illegal == '0)); // R1
endmodule

// File: tb/tb_gcube_net.sv
module tb_gcube_net;
   localparam int M = 3, N = 8, W = 8, LAT = 3;

   logic           clk = 1'b0;
   logic           rst_n;
   logic [N-1:0]   in_valid;
   logic [N*W-1:0] in_data;
   logic [N*M-1:0] in_dest;
   logic [M-1:0]   part_mask;
   logic [N-1:0]   out_valid;
   logic [N*W-1:0] out_data;
   logic [M-1:0]   conflict, illegal;
   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   gcube_net #(.M(M), .W(W), .STAGE_REG(1'b1)) dut (.*);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_in();
      in_valid = '0; in_data = '0; in_dest = '0;
   endtask

   task automatic put(input int j, input int dst, input logic [7:0] dat);
      in_valid[j] = 1'b1;
      in_dest[j*M +: M] = M'(dst);
      in_data[j*W +: W] = dat;
   endtask

   task automatic settle();
      repeat (LAT) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_xor(input int k, input logic [M-1:0] mask, input string req);
      clear_in(); part_mask = mask;
      for (int j = 0; j < N; j++) put(j, j ^ k, 8'(8'h30 + j * 3 + k));
      settle();
      chk({req, " valid"}, 64'(out_valid), 64'hFF);
      for (int j = 0; j < N; j++)
         chk({req, " data"}, 64'(out_data[(j ^ k)*W +: W]), 64'(8'(8'h30 + j * 3 + k)));
      chk({req, " flags"}, 64'({conflict, illegal}), 64'h0);
   endtask

   task automatic t_conf_stage2();
      clear_in(); part_mask = '0;
      put(0, 3, 8'h11); put(4, 3, 8'h44);
      settle();
      chk("R4 winner valid", 64'(out_valid), 64'h08);
      chk("R4 winner data", 64'(out_data[3*W +: W]), 64'h11);
      chk("R4 conflict stage2", 64'(conflict), 64'b100);
   endtask

   task automatic t_conf_stage0();
      clear_in(); part_mask = '0;
      put(0, 6, 8'hA5); put(1, 6, 8'h5A);
      settle();
      chk("R4 stage0 valid", 64'(out_valid), 64'h40);
      chk("R4 stage0 data", 64'(out_data[6*W +: W]), 64'hA5);
      chk("R4 stage0 flag", 64'({conflict, illegal}), 64'({3'b001, 3'b000}));
   endtask

   task automatic t_illegal(input logic [M-1:0] mask, input int src, input int dst,
                            input logic [M-1:0] exp_ill);
      clear_in(); part_mask = mask;
      put(src, dst, 8'h77);
      settle();
      chk("R5 dropped", 64'(out_valid), 64'h0);
      chk("R5 illegal", 64'(illegal), 64'(exp_ill));
      chk("R5 no conflict", 64'(conflict), 64'h0);
   endtask

   task automatic t_invalid();
      clear_in(); part_mask = 3'b101;
      for (int j = 0; j < N; j++) begin
         in_dest[j*M +: M] = '0;
         in_data[j*W +: W] = 8'hEE;
      end
      settle();
      chk("R7 no output", 64'(out_valid), 64'h0);
      chk("R7 no flags", 64'({conflict, illegal}), 64'h0);
   endtask

   task automatic t_pipeline();
      clear_in(); part_mask = '0;
      settle();
      for (int j = 0; j < N; j++) put(j, j, 8'(8'h10 + j));
      @(posedge clk); @(negedge clk);
      clear_in();
      for (int j = 0; j < N; j++) put(j, j ^ 7, 8'(8'h40 + j));
      @(posedge clk); @(negedge clk);
      clear_in();
      chk("R2 not early", 64'(out_valid), 64'h0);
      @(posedge clk); @(negedge clk);
      chk("R2 first set valid", 64'(out_valid), 64'hFF);
      chk("R2 first set data", 64'(out_data[5*W +: W]), 64'h15);
      @(posedge clk); @(negedge clk);
      chk("R2 second set valid", 64'(out_valid), 64'hFF);
      chk("R2 second set data", 64'(out_data[2*W +: W]), 64'h45);
      @(posedge clk); @(negedge clk);
      chk("R2 drained", 64'(out_valid), 64'h0);
   endtask

   task automatic t_flags_follow();
      clear_in(); part_mask = '0;
      put(0, 3, 8'h01); put(4, 3, 8'h02);
      @(posedge clk); @(negedge clk);
      clear_in(); put(2, 2, 8'h22);
      repeat (LAT - 1) @(posedge clk);
      @(negedge clk);
      chk("R8 flagged set", 64'(conflict), 64'b100);
      @(posedge clk); @(negedge clk);
      chk("R8 clean set flags", 64'({conflict, illegal}), 64'h0);
      chk("R8 clean set data", 64'(out_data[2*W +: W]), 64'h22);
   endtask

   initial begin
      #(8 * 20000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0; part_mask = '0; clear_in();
      for (int j = 0; j < N; j++) put(j, j, 8'(j));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset outputs", 64'({out_valid, conflict, illegal}), 64'h0);
      rst_n = 1'b1;
      clear_in();
      @(posedge clk); @(negedge clk);
      chk("R1 after reset", 64'({out_valid, conflict, illegal}), 64'h0);
      t_xor(0, 3'b000, "R3 identity");
      t_xor(7, 3'b000, "R3 reversal");
      t_xor(5, 3'b000, "R3 xor5");
      t_conf_stage2();
      t_conf_stage0();
      t_xor(6, 3'b001, "R6 mask0");
      t_xor(3, 3'b100, "R6 mask2");
      t_xor(2, 3'b101, "R6 mask02");
      t_illegal(3'b001, 2, 3, 3'b001);
      t_illegal(3'b100, 1, 5, 3'b100);
      t_invalid();
      t_pipeline();
      t_flags_follow();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule